// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address into a physical address by fetching one entry of a single-level page table that lives in physical memory. A requester offers a virtual address together with a read/write flag. The block splits the address into a 10-bit in-page offset and a virtual page number. It adds four times the page number to a table base supplied on an input port. It then issues exactly one read of that table word through a simple request/response memory port.

When the table word returns, the block checks the present bit first and the access-rights bit for the requested kind of access second. It then reports the outcome with a one-cycle done pulse. The pulse carries either the physical address, which is the frame number from the entry joined with the untouched offset, or a fault code. Only one translation is in flight at a time. The request side stays not-ready until the current translation has been reported.

Top module: `page_xlate`

## Requirements
- R1: After reset, req_ready is 1, mem_rd_valid is 0 and done is 0.
- R2: For an accepted request, exactly one table read is issued, at address pt_base + 4 × vpn (modulo 2^32), where vpn is req_vaddr[31:10]. pt_base is assumed word-aligned and is added as given.
- R3: While mem_rd_valid is 1 and mem_rd_ready is 0, mem_rd_valid stays 1 and mem_rd_addr stays unchanged.
- R4: From the cycle after a request is accepted until done is reported, req_ready is 0. A request held valid during that time is not accepted a second time.
- R5: done is a single-cycle pulse, high in the cycle right after the cycle in which mem_rsp_valid is sampled high while a read is outstanding.
- R6: Table entry layout: bit 0 is present, bit 1 is read permission, bit 2 is write permission, bits 31:10 are the frame number, and bits 9:3 are ignored. A present, permitted access reports done_fault = 00 and done_paddr = {entry[31:10], req_vaddr[9:0]}.
- R7: An entry with bit 0 clear reports done_fault = 01 (not present) and done_paddr = 0, whatever its permission bits hold. This check takes priority over the rights check.
- R8: A present entry reports done_fault = 10 (protection) and done_paddr = 0 in two cases: a write when bit 2 is clear, or a read when bit 1 is clear.
- R9: pt_base is sampled when the request is accepted. Changing it while a translation is in flight does not alter that translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| pt_base | input | 32 | Physical base address of the page table |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Address of the table entry |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table entry |
| done | output | 1 | Result pulse |
| done_paddr | output | 32 | Physical address (0 on a fault) |
| done_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
A request accepted at clock edge k raises mem_rd_valid after that edge. The read handshake completes on the first edge at which mem_rd_ready is high. The result appears one edge after the edge that samples mem_rsp_valid. The bench's memory model stalls the read and delays the response by different amounts. It logs the cycle in which it raised mem_rsp_valid and the address it was handed. The monitor samples on falling edges and requires done exactly one cycle after that logged cycle. At that point it compares the physical address, the fault code, the table address and the read count against the scoreboard entry. req_ready is checked on the falling edge right after acceptance, and the read address is checked on every stalled cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int PTE_SHIFT = 2;   // table entries are 4 bytes wide
    localparam int FLAG_W    = 3;   // present, read, write

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } xl_state_e;

    // Field order matches entry bits [2:0]: write, read, present
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic present;
    } pte_flags_t;

    // Present is judged first, rights second
    function automatic fault_e judge_access(input pte_flags_t f, input logic is_write);
        if (!f.present) begin
            return FLT_ABSENT;
        end
        if (is_write ? !f.wr_ok : !f.rd_ok) begin
            return FLT_PROT;
        end
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/xl_addr_split.sv
module xl_addr_split
    import xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFS_W = 10
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  base,
    output logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int SCALED_W = VPN_W + PTE_SHIFT;

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  scaled;

    assign vpn = vaddr[VA_W-1:OFS_W];
    assign ofs = vaddr[OFS_W-1:0];

    generate
        if (SCALED_W >= PA_W) begin : g_trunc
            assign scaled = PA_W'({vpn, {PTE_SHIFT{1'b0}}});
        end else begin : g_ext
            assign scaled = {{(PA_W-SCALED_W){1'b0}}, vpn, {PTE_SHIFT{1'b0}}};
        end
    endgenerate

    assign entry_addr = base + scaled;

endmodule

// File: rtl/xl_pte_check.sv
module xl_pte_check
    import xlate_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFS_W = 10
) (
    input  logic [PA_W-1:0]  entry,
    input  logic [OFS_W-1:0] ofs,
    input  logic             is_write,
    output logic [PA_W-1:0]  paddr,
    output fault_e           fault
);
    localparam logic [PA_W-1:0] FRAME_MASK = {{(PA_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

    pte_flags_t flags;

    assign flags = pte_flags_t'(entry[FLAG_W-1:0]);

    always_comb begin
        fault = judge_access(flags, is_write);
        if (fault == FLT_NONE) begin
            paddr = (entry & FRAME_MASK) | {{(PA_W-OFS_W){1'b0}}, ofs};
        end else begin
            paddr = '0;
        end
    end

endmodule

// File: rtl/xl_ctrl.sv
module xl_ctrl
    import xlate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic mem_rd_valid,
    input  logic mem_rd_ready,
    input  logic mem_rsp_valid,
    output logic accept,
    output logic finish
);
    xl_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (req_valid)     state_q <= ST_ISSUE;
                ST_ISSUE: if (mem_rd_ready)  state_q <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state_q <= ST_IDLE;
                default:                     state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign accept       = req_valid && req_ready;
    assign finish       = (state_q == ST_WAIT) && mem_rsp_valid;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R4

    AST_NO_READ_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready); // R4

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [PA_W-1:0]  pt_base,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data,
    output logic             done,
    output logic [PA_W-1:0]  done_paddr,
    output logic [1:0]       done_fault
);
    logic             accept;
    logic             finish;
    logic [OFS_W-1:0] ofs_d;
    logic [PA_W-1:0]  eaddr_d;
    logic [OFS_W-1:0] ofs_q;
    logic [PA_W-1:0]  eaddr_q;
    logic             wr_q;
    logic [PA_W-1:0]  paddr_d;
    fault_e           fault_d;
    logic             done_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    xl_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .accept       (accept),
        .finish       (finish)
    );

    xl_addr_split #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_split (
        .vaddr     (req_vaddr),
        .base      (pt_base),
        .ofs       (ofs_d),
        .entry_addr(eaddr_d)
    );

    xl_pte_check #(.PA_W(PA_W), .OFS_W(OFS_W)) u_check (
        .entry   (mem_rsp_data),
        .ofs     (ofs_q),
        .is_write(wr_q),
        .paddr   (paddr_d),
        .fault   (fault_d)
    );

    // Request capture: base and address are frozen at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q   <= '0;
            eaddr_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            ofs_q   <= ofs_d;
            eaddr_q <= eaddr_d;
            wr_q    <= req_write;
        end
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            done_q <= finish;
            if (finish) begin
                paddr_q <= paddr_d;
                fault_q <= fault_d;
            end
        end
    end

    assign mem_rd_addr = eaddr_q;
    assign done        = done_q;
    assign done_paddr  = paddr_q;
    assign done_fault  = fault_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rsp_valid)); // R5

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault == FLT_NONE) |-> (done_paddr[OFS_W-1:0] == $past(ofs_q))); // R6

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault != FLT_NONE) |-> (done_paddr == '0)); // R7

endmodule

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] pt_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    always #4 clk = ~clk;   // 125 MHz

    page_xlate uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(pt_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    typedef struct {
        logic [31:0] eaddr;
        logic [31:0] paddr;
        logic [1:0]  fault;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] pt [0:63];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          stall_n = 0;
    int          lat_n = 0;
    int          rd_cnt = 0;
    int          rsp_cyc = 0;
    logic [31:0] seen_addr = '0;
    logic        finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pte(input logic [21:0] frame, input logic w, input logic r, input logic v);
        return {frame, 7'b0, w, r, v};
    endfunction

    // Memory model: word at addr is pt[addr[7:2]]
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                seen_addr = mem_rd_addr;
                for (int s = 0; s < stall_n; s++) begin
                    @(negedge clk);
                    chk(mem_rd_valid && mem_rd_addr == seen_addr, "R3 read held while stalled",
                        mem_rd_addr, seen_addr);
                end
                mem_rd_ready = 1'b1;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                rd_cnt++;
                for (int l = 0; l < lat_n; l++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pt[seen_addr[7:2]];
                rsp_cyc       = cyc;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'hDEAD_BEEF;
            end
        end
    end

    // Monitor: pop and compare on each done
    initial begin
        logic prev_done;
        exp_t e;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done && prev_done)
                    chk(1'b0, "R5 done wider than one cycle", 32'd2, 32'd1);
                if (done) begin
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected done", 32'd1, 32'd0);
                    end else begin
                        e = sb_q.pop_front();
                        chk(cyc == rsp_cyc + 1, "R5 done timing", cyc, rsp_cyc + 1);
                        chk(seen_addr == e.eaddr, "R2 entry address", seen_addr, e.eaddr);
                        chk(rd_cnt == 1, "R2 R4 one read per translation", rd_cnt, 32'd1);
                        chk(done_fault == e.fault, "R6 R7 R8 fault code", {30'b0, done_fault}, {30'b0, e.fault});
                        chk(done_paddr == e.paddr, "R6 R7 R8 physical address", done_paddr, e.paddr);
                    end
                    rd_cnt = 0;
                end
                prev_done = done;
            end
        end
    end

    // Driver: compute expectation, push, then run one translation
    task automatic xlate(input logic [31:0] va, input logic wr, input bit hold, input logic [31:0] new_base_mid);
        exp_t        e;
        logic [31:0] ent;
        e.eaddr = pt_base + {va[31:10], 2'b00};
        ent     = pt[e.eaddr[7:2]];
        if (!ent[0]) begin
            e.fault = 2'b01; e.paddr = '0;
        end else if ((wr && !ent[2]) || (!wr && !ent[1])) begin
            e.fault = 2'b10; e.paddr = '0;
        end else begin
            e.fault = 2'b00; e.paddr = {ent[31:10], va[9:0]};
        end
        sb_q.push_back(e);
        @(negedge clk);
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R4 not ready while busy", {31'b0, req_ready}, 32'd0);
        if (new_base_mid != 32'hFFFF_FFFF) pt_base = new_base_mid;   // R9
        if (!hold) req_valid = 1'b0;
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) pt[i] = '0;
        pt[1]  = mk_pte(22'h12345, 1'b0, 1'b1, 1'b1);   // read only
        pt[2]  = mk_pte(22'h00ABC, 1'b1, 1'b1, 1'b1);   // read/write
        pt[3]  = mk_pte(22'h11111, 1'b1, 1'b1, 1'b0);   // not present
        pt[4]  = mk_pte(22'h0F0F0, 1'b1, 1'b0, 1'b1);   // write only
        pt[6]  = mk_pte(22'h3FFFFF, 1'b1, 1'b1, 1'b1) | 32'h0000_03F8; // ignored bits set
        pt[63] = mk_pte(22'h2A5A5, 1'b0, 1'b1, 1'b1);

        pt_base = 32'h1000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset req_ready", {31'b0, req_ready}, 32'd1);
        chk(mem_rd_valid == 1'b0, "R1 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
        chk(done == 1'b0, "R1 reset done", {31'b0, done}, 32'd0);

        // R6: permitted accesses, offset extremes
        xlate({22'd1, 10'h3FF}, 1'b0, 0, 32'hFFFF_FFFF);
        xlate({22'd2, 10'h000}, 1'b1, 0, 32'hFFFF_FFFF);
        xlate({22'd6, 10'h155}, 1'b0, 0, 32'hFFFF_FFFF);
        // R8: protection faults
        xlate({22'd1, 10'h010}, 1'b1, 0, 32'hFFFF_FFFF);
        xlate({22'd4, 10'h020}, 1'b0, 0, 32'hFFFF_FFFF);
        xlate({22'd4, 10'h021}, 1'b1, 0, 32'hFFFF_FFFF);
        // R7: not present beats rights; empty entry
        xlate({22'd3, 10'h001}, 1'b1, 0, 32'hFFFF_FFFF);
        xlate({22'd5, 10'h002}, 1'b0, 0, 32'hFFFF_FFFF);
        // R2: largest page number wraps into the table top
        xlate({22'h3FFFFF, 10'h3C3}, 1'b0, 0, 32'hFFFF_FFFF);
        // R3 R5: stalled read and slow response
        stall_n = 3; lat_n = 4;
        xlate({22'd2, 10'h0AB}, 1'b0, 0, 32'hFFFF_FFFF);
        // R4: request held valid through the translation
        stall_n = 1; lat_n = 2;
        xlate({22'd1, 10'h111}, 1'b0, 1, 32'hFFFF_FFFF);
        // R2: new base shifts the indexed entry
        stall_n = 0; lat_n = 0;
        pt_base = 32'h2000_0010;
        xlate({22'd0, 10'h033}, 1'b1, 0, 32'hFFFF_FFFF);
        xlate({22'd1, 10'h044}, 1'b0, 0, 32'hFFFF_FFFF);
        // R9: base changed mid-flight does not affect this translation
        stall_n = 2; lat_n = 1;
        pt_base = 32'h1000_0000;
        xlate({22'd2, 10'h077}, 1'b1, 0, 32'h3000_0000);

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R5 all results reported", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule